// File: doc/BRIEF.md
# Four-Channel Fault Qualifier and Diagnosis Latch

This block sits between the comparator outputs of four low-side power channels and the serial diagnosis logic. Each channel has four raw fault indications: over-current, over-temperature, open load and short to ground. It also has the commanded on/off state for the channel.

Over-current, open load and short to ground must each persist for a programmable number of clock cycles before the matching flag latches. Over-temperature latches on the next clock edge. It also blanks the channel's gate enable combinationally, and the gate returns by itself once the raw input clears. Latched flags are summarised three ways: a 2-bit status code per channel, a 1-bit no-fault indication per channel, and one active-low fault line shared by all channels.

The flags clear only when a serial frame ends properly. The block counts bit strobes while chip select is low. A frame counts as valid when chip select rises after a non-zero whole multiple of `FRAME_BITS` strobes.

Top module: `chan_diag_latch`

## Requirements
- R1: A raw over-current, open-load or short-to-ground input must be high on `FILT_CYC` consecutive clock edges to set its flag. The flag is set on the `FILT_CYC`-th such edge and not before.
- R2: If a raw over-current, open-load or short-to-ground input is low on any edge, its filter restarts from zero. The full `FILT_CYC` run is then needed again.
- R3: A raw over-temperature input sets the channel's protection flag on the next clock edge. While the input is high, `gate_en` for that channel is 0 with no clock delay. Otherwise `gate_en` follows `ch_cmd`, so the channel restarts by itself when the temperature returns to normal.
- R4: `prot_flag[i]` is the OR of channel i's latched over-current and over-temperature flags.
- R5: `status_code[2i+1:2i]` encodes the latched state of channel i:
  - 10 when the protection flag is set;
  - otherwise 00 when the short-to-ground flag is set;
  - otherwise 01 when the open-load flag is set;
  - 11 when no flag is set.
- R6: `fault_ok[i]` is 1 when channel i has no latched flag and 0 otherwise.
- R7: `fault_n` is 0 while any flag of any channel is set, and 1 otherwise.
- R8: All flags and filters clear on the clock edge where `cs_n` is first sampled high. This happens only if, during that low period, the count of `bit_tick` strobes sampled with `cs_n` low is non-zero and a whole multiple of `FRAME_BITS`. A frame with 7 strobes, or with none, leaves the flags set.
- R9: A fault still present across a clear sets its flag again exactly `FILT_CYC` edges after the clearing edge.
- R10: `rst_n` low asynchronously returns all flags, filters and frame state to their defaults. The defaults are status 11 on every channel and `fault_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / sleep request |
| raw_oc | input | NCH | Raw over-current per channel |
| raw_ot | input | NCH | Raw over-temperature per channel |
| raw_ol | input | NCH | Raw open load per channel |
| raw_sg | input | NCH | Raw short to ground per channel |
| ch_cmd | input | NCH | Commanded on state per channel |
| cs_n | input | 1 | Serial chip select, active low, synchronous |
| bit_tick | input | 1 | One-cycle strobe per serial bit sampled |
| gate_en | output | NCH | Gate drive enable after thermal shutdown |
| prot_flag | output | NCH | Latched protection flag |
| ol_flag | output | NCH | Latched open-load flag |
| sg_flag | output | NCH | Latched short-to-ground flag |
| fault_ok | output | NCH | 1 = no fault latched on channel |
| status_code | output | 2*NCH | 2-bit status per channel |
| fault_n | output | 1 | Active-low fault summary |

## Verification
Filtered flags appear after the `FILT_CYC`-th consecutive edge with the raw input high. The bench holds a fault for an exact edge count and samples on the following falling edge, so a hold of `FILT_CYC-1` edges must still read clean. Over-temperature reaches the flag one edge after it is driven, and it reaches `gate_en` with no edge at all; the bench checks the gate a short delay after driving the input. A clear takes effect on the edge that first samples `cs_n` high, so the frame task returns on the next falling edge and the check follows at once. The re-set after a clear is then counted from that edge.

// File: rtl/chan_diag_latch.sv
module chan_diag_latch #(
  parameter int NCH        = 4,
  parameter int FILT_CYC   = 27500,
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   raw_oc,
  input  logic [NCH-1:0]   raw_ot,
  input  logic [NCH-1:0]   raw_ol,
  input  logic [NCH-1:0]   raw_sg,
  input  logic [NCH-1:0]   ch_cmd,
  input  logic             cs_n,
  input  logic             bit_tick,
  output logic [NCH-1:0]   gate_en,
  output logic [NCH-1:0]   prot_flag,
  output logic [NCH-1:0]   ol_flag,
  output logic [NCH-1:0]   sg_flag,
  output logic [NCH-1:0]   fault_ok,
  output logic [2*NCH-1:0] status_code,
  output logic             fault_n
);
  localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam int FW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST  = CW'(FILT_CYC - 1);
  localparam logic [FW-1:0] FLAST = FW'(FRAME_BITS - 1);

  logic          cs_q, seen, clr;
  logic [FW-1:0] bit_cnt;

  assign clr = cs_n & ~cs_q & seen & (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q    <= 1'b1;
      seen    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        seen    <= 1'b0;
        bit_cnt <= '0;
      end else if (bit_tick) begin
        seen    <= 1'b1;
        bit_cnt <= (bit_cnt == FLAST) ? '0 : bit_cnt + 1'b1;
      end
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          f_oc, f_ot, f_ol, f_sg;
    logic [CW-1:0] c_oc, c_ol, c_sg;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        {f_oc, f_ot, f_ol, f_sg} <= '0;
        c_oc <= '0;
        c_ol <= '0;
        c_sg <= '0;
      end else if (clr) begin
        {f_oc, f_ot, f_ol, f_sg} <= '0;
        c_oc <= '0;
        c_ol <= '0;
        c_sg <= '0;
      end else begin
        c_oc <= !raw_oc[i] ? '0 : (c_oc == LAST) ? LAST : c_oc + 1'b1;
        c_ol <= !raw_ol[i] ? '0 : (c_ol == LAST) ? LAST : c_ol + 1'b1;
        c_sg <= !raw_sg[i] ? '0 : (c_sg == LAST) ? LAST : c_sg + 1'b1;
        if (raw_oc[i] && c_oc == LAST) f_oc <= 1'b1;
        if (raw_ol[i] && c_ol == LAST) f_ol <= 1'b1;
        if (raw_sg[i] && c_sg == LAST) f_sg <= 1'b1;
        if (raw_ot[i]) f_ot <= 1'b1;
      end

    assign gate_en[i]   = ch_cmd[i] & ~raw_ot[i];
    assign prot_flag[i] = f_oc | f_ot;
    assign ol_flag[i]   = f_ol;
    assign sg_flag[i]   = f_sg;
    assign fault_ok[i]  = ~(prot_flag[i] | f_ol | f_sg);
    assign status_code[2*i +: 2] = prot_flag[i] ? 2'b10 :
                                   f_sg         ? 2'b00 :
                                   f_ol         ? 2'b01 : 2'b11;

    p_ol_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ol_flag[i]) |-> $past(raw_ol[i]));
    p_sg_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sg_flag[i]) |-> $past(raw_sg[i]));
    p_ot_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_ot[i] && !clr) |=> prot_flag[i]);
  end

  assign fault_n = ~|{prot_flag, ol_flag, sg_flag};

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (((ol_flag & $past(ol_flag)) == $past(ol_flag)) &&
              ((sg_flag & $past(sg_flag)) == $past(sg_flag))));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ol_flag == '0 && sg_flag == '0));
  p_faultn_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(|{raw_oc, raw_ot, raw_ol, raw_sg}));
endmodule

// File: tb/chan_diag_latch_tb_top.sv
module chan_diag_latch_tb_top;
  localparam int NCH = 4;
  localparam int FC  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] raw_oc, raw_ot, raw_ol, raw_sg, ch_cmd;
  logic cs_n, bit_tick;
  logic [NCH-1:0] gate_en, prot_flag, ol_flag, sg_flag, fault_ok;
  logic [2*NCH-1:0] status_code;
  logic fault_n;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  chan_diag_latch #(.NCH(NCH), .FILT_CYC(FC), .FRAME_BITS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_oc(raw_oc), .raw_ot(raw_ot),
    .raw_ol(raw_ol), .raw_sg(raw_sg), .ch_cmd(ch_cmd), .cs_n(cs_n),
    .bit_tick(bit_tick), .gate_en(gate_en), .prot_flag(prot_flag),
    .ol_flag(ol_flag), .sg_flag(sg_flag), .fault_ok(fault_ok),
    .status_code(status_code), .fault_n(fault_n));

  // raw pattern {sg, ol, ot, oc}; status packed ch3..ch0
  localparam logic [15:0] V_RAW  [8] = '{16'h0001, 16'h0001, 16'h0020, 16'h0400,
                                         16'h8000, 16'h4400, 16'h1101, 16'h0280};
  localparam int          V_HOLD [8] = '{8, 7, 1, 8, 8, 8, 8, 8};
  localparam logic [7:0]  V_STAT [8] = '{8'hFE, 8'hFF, 8'hFB, 8'hDF,
                                         8'h3F, 8'hCF, 8'hFE, 8'hB7};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_raw(input logic [15:0] r);
    {raw_sg, raw_ol, raw_ot, raw_oc} = r;
  endtask

  task automatic frame(input int nbits);
    @(negedge clk) cs_n = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; drive_raw(16'h0); ch_cmd = '0; cs_n = 1'b1; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(status_code, 8'hFF, "R10 reset status");
    chk(fault_n, 1'b1, "R10 reset fault_n");
    chk(fault_ok, 4'hF, "R6 reset fault_ok");
    chk(gate_en, 4'h0, "R3 gate off when not commanded");
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      drive_raw(V_RAW[k]);
      hold(V_HOLD[k]);
      chk(status_code, V_STAT[k], $sformatf("R1 R5 vector %0d status", k));
      chk(fault_n, (V_STAT[k] == 8'hFF), $sformatf("R7 vector %0d fault_n", k));
      drive_raw(16'h0);
      frame(8);
      chk(status_code, 8'hFF, $sformatf("R8 vector %0d cleared", k));
    end

    ch_cmd = 4'hF;
    raw_ot = 4'b0100;
    #1 chk(gate_en, 4'b1011, "R3 gate blanked at once");
    @(negedge clk);
    chk(prot_flag, 4'b0100, "R4 protection from over-temperature");
    chk(fault_ok, 4'b1011, "R6 fault_ok per channel");
    raw_ot = 4'b0000;
    #1 chk(gate_en, 4'hF, "R3 automatic restart");
    chk(status_code, 8'hEF, "R3 flag stays latched");
    frame(8);

    raw_ol = 4'b0001;
    hold(FC);
    raw_ol = 4'b0000;
    chk(status_code, 8'hFD, "R1 open load latched");
    frame(7);
    chk(status_code, 8'hFD, "R8 seven-bit frame keeps flags");
    frame(0);
    chk(status_code, 8'hFD, "R8 empty frame keeps flags");
    frame(16);
    chk(status_code, 8'hFF, "R8 sixteen-bit frame clears");

    raw_oc = 4'b0001;
    hold(5);
    raw_oc = 4'b0000;
    hold(1);
    raw_oc = 4'b0001;
    hold(5);
    chk(status_code, 8'hFF, "R2 interrupted fault not latched");
    hold(FC - 5);
    chk(status_code, 8'hFE, "R2 full run after restart latches");
    chk(prot_flag, 4'b0001, "R4 protection from over-current");
    raw_oc = 4'b0000;
    frame(8);

    raw_sg = 4'b1000;
    hold(FC);
    chk(status_code, 8'h3F, "R9 short latched");
    frame(8);
    chk(status_code, 8'hFF, "R9 clear while fault present");
    hold(FC - 1);
    chk(status_code, 8'hFF, "R9 not yet re-set");
    hold(1);
    chk(status_code, 8'h3F, "R9 re-set after full delay");
    raw_sg = 4'b0000;
    frame(8);

    raw_oc = 4'b0010;
    hold(FC);
    chk(status_code, 8'hFB, "R1 over-current ch1");
    raw_oc = 4'b0000;
    rst_n = 1'b0;
    #1 chk(status_code, 8'hFF, "R10 reset clears flags");
    chk(fault_n, 1'b1, "R10 reset fault_n high");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule